// File: doc/BRIEF.md
# Randomized Transmission Scatter Timer

This block puts a pseudo-random wait between the moment a sampling routine decides to send a telemetry message and the moment the transmission actually begins. Several transmitters that sample on the same schedule would otherwise send in the same slots every time. A random offset in each message breaks that fixed pattern and spreads the collisions out.

Software arms the timer with a single-cycle pulse at the end of the sampling interrupt. The block then takes a fresh delay of 0 to 7 periods of the slow real-time clock and counts it down on that clock's enable, not on system-clock cycles. The real-time clock runs at 32.768 kHz, so a sampling rate of 1024 per second leaves 32 slow periods between sampling events, and the longest delay fits well inside that gap. When the count expires, the block raises a transmit interrupt. That interrupt stays up until software acknowledges it. A free-running 16-bit maximal-length shift register, stepped on every slow tick, supplies the random value.

Top module: `scatter_timer`

## Requirements
- R1: After reset, busy and tx_irq are low and the random register holds the SEED parameter (default 16'hACE1). With no tick before the first arm, that arm therefore uses delay SEED[2:0].
- R2: The 16-bit random register steps only in cycles where tick is high. Each step shifts left by one, and the new bit 0 is the XOR of bits 15, 13, 12 and 10. Its value never becomes zero.
- R3: An arm pulse while the block is idle takes the low 3 bits of the random register as the delay d. It uses the value the register holds in the arm cycle, before any step in that same cycle. busy reads high from the next cycle on.
- R4: Counting only the ticks in cycles after the arm cycle, tx_irq goes high in the cycle after the (d+1)-th such tick, and not earlier.
- R5: A delay of zero raises tx_irq on the first tick after the arm cycle.
- R6: Once high, tx_irq and busy stay high until ack is sampled high. They are both low in the following cycle.
- R7: An arm pulse while busy is high is ignored. It changes neither the remaining delay nor a pending interrupt.
- R8: An ack pulse while tx_irq is low has no effect on the running delay or on busy.
- R9: Ticks alone, with no arm, never raise tx_irq or busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle enable per real-time clock period |
| arm | input | 1 | Start a random delay (end of sampling decision) |
| ack | input | 1 | Acknowledge and clear the transmit interrupt |
| tx_irq | output | 1 | Transmit interrupt, held until acknowledged |
| busy | output | 1 | High from arm until acknowledge |

## Verification
A wrong random register shows up on the very next arm: the interrupt arrives one or more ticks early or late compared with the delay the bench computes from the polynomial. A bad down-counter or state register shows as an interrupt on the wrong tick, as a busy flag that drops before acknowledge, or as an arm pulse while busy that restarts the count. Each of these is visible within at most eight ticks of the arm that exposes it. Sweeping hundreds of arms, at shifting register phases and with arm coinciding with a tick, covers every delay value from 0 to 7.

// File: rtl/scatter_timer.sv
module scatter_timer #(
  parameter logic [15:0] SEED    = 16'hACE1,
  parameter int          DELAY_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic arm,
  input  logic ack,
  output logic tx_irq,
  output logic busy
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_PEND} state_t;

  state_t             state;
  logic [15:0]        lfsr;
  logic [DELAY_W-1:0] cnt;
  logic               fb;

  assign fb     = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];
  assign busy   = (state != S_IDLE);
  assign tx_irq = (state == S_PEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lfsr <= SEED;
    else if (tick) lfsr <= {lfsr[14:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (arm) begin
          state <= S_WAIT;
          cnt   <= lfsr[DELAY_W-1:0];
        end
        S_WAIT: if (tick) begin
          if (cnt == '0) state <= S_PEND;
          else           cnt   <= cnt - 1'b1;
        end
        S_PEND: if (ack) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_lfsr_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n) lfsr != 16'h0);
  p_lfsr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(lfsr));
  p_irq_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_irq) |-> $past(tick));
  p_irq_held_r6: assert property (@(posedge clk) disable iff (!rst_n) tx_irq && !ack |=> tx_irq);
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n) tx_irq && ack |=> !busy);
  p_arm_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tx_irq && arm && !tick |=> $stable(cnt) && busy && !tx_irq);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n) !busy |=> !tx_irq);

endmodule

// File: tb/scatter_timer_tb.sv
module scatter_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, arm = 1'b0, ack = 1'b0;
  logic tx_irq, busy;
  int checks = 0, errors = 0;
  logic [15:0] m_lfsr = 16'hACE1;
  bit done = 0;

  scatter_timer u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .arm(arm), .ack(ack),
                       .tx_irq(tx_irq), .busy(busy));

  always #10 clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", what, act, exp, $time);
    end
  endtask

  task automatic drive(input logic t, input logic a, input logic k);
    tick = t; arm = a; ack = k;
    @(posedge clk);
    if (t) m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    @(negedge clk);
    tick = 0; arm = 0; ack = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d, n;
    bit seen;
    repeat (3) @(negedge clk);
    chk(busy, 1'b0, "R1 busy after reset");
    chk(tx_irq, 1'b0, "R1 irq after reset");
    rst_n = 1'b1;
    @(negedge clk);
    for (int trial = 0; trial < 300; trial++) begin
      for (int i = 0; i < (trial * 7) % 5 + trial % 3; i++) begin
        drive(1, 0, 0);
        chk(tx_irq, 1'b0, "R9 tick without arm irq");
        chk(busy, 1'b0, "R9 tick without arm busy");
      end
      d = m_lfsr[2:0];
      if (trial == 0) chk(d == 1, 1'b1, "R1 first delay equals seed low bits");
      drive(trial % 4 == 0, 1, 0);
      chk(busy, 1'b1, "R3 busy after arm");
      chk(tx_irq, 1'b0, "R3 no irq at arm");
      n = 0;
      seen = 0;
      while (!seen) begin
        if (n % 3 == 1) drive(0, 1, 0);
        if (n % 3 == 2) drive(0, 0, 1);
        if (n % 2 == 1) drive(0, 0, 0);
        chk(tx_irq, 1'b0, "R7/R8 irq before expiry");
        chk(busy, 1'b1, "R7/R8 busy while waiting");
        drive(1, 0, 0);
        n++;
        if (n == d + 1) begin
          chk(tx_irq, 1'b1, d == 0 ? "R5 zero delay irq" : "R4 irq at d+1 ticks");
          seen = 1;
        end else begin
          chk(tx_irq, 1'b0, "R4 irq too early");
          if (n > 8) begin
            chk(1'b0, 1'b1, "R4 irq never came");
            seen = 1;
          end
        end
      end
      drive(1, 1, 0);
      chk(tx_irq, 1'b1, "R6/R7 irq held, arm ignored");
      drive(0, 0, 0);
      chk(busy, 1'b1, "R6 busy held");
      drive(trial % 2, 0, 1);
      chk(tx_irq, 1'b0, "R6 irq cleared by ack");
      chk(busy, 1'b0, "R6 busy cleared by ack");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule